// File: doc/BRIEF.md
# Hill-Climbing Window Size Controller

This block decides at run time how many bank groups of an out-of-order instruction window are powered and in use. Window sizes are powers of two in whole bank groups, written as a level L where 2^L groups are enabled. The controller works in sampling epochs, and each epoch lasts a fixed number of committed instructions. During one epoch it adds up a cycle count and an energy estimate that the surrounding logic supplies on every clock.

A round of sampling measures three sizes in a fixed order: the present level, one level smaller, and one level larger. A size that falls outside the configured level range is skipped. Each sample covers the same number of instructions, so the best throughput-cubed-per-watt figure is the smallest product cycles² × energy. The controller finds this with multipliers and no divider. It then moves to the winning size, keeps that size for a programmable number of epochs, and starts the next round from it.

A larger window takes effect on the clock after it is requested. A smaller window waits until the core reports that the groups about to be switched off are drained.

Top module: `win_scale_ctrl`

## Requirements
- R1: While reset is high, and directly after it, both the enable mask and the target mask hold the initial level. The enable mask is bit g set for every g < 2^INIT_LVL, so the bench configuration gives 8'h03.
- R2: The enable mask is always a contiguous run of ones from bit 0, with a power-of-two length between 2^MIN_LVL and 2^MAX_LVL.
- R3: A round samples the present level first, then the level below it, then the level above it. Each sample counts exactly EPOCH_INSTR commit pulses. Only pulses that arrive while measuring are counted. After the clock edge that applies a size, the next size request is issued EPOCH_INSTR+1 edges later.
- R4: A candidate level below MIN_LVL or above MAX_LVL is not sampled, and the round moves on to the next candidate or ends.
- R5: At the end of a round the level with the smallest cycles² × energy is chosen. On equal cost the present level wins over the smaller one, and the smaller one wins over the larger one.
- R6: After the chosen level is applied, it is held for hold_epochs_i epochs. The next round's first measurement is then applied EPOCH_INSTR × hold_epochs_i + 1 edges later. When hold_epochs_i is 0, the gap is 1 edge.
- R7: A request for a larger size is applied on the next clock edge. A request for a smaller size is applied only on an edge where drain_ok_i is high. No group is ever disabled on an edge where drain_ok_i is low.
- R8: tgt_en_o shows the requested size in the same mask encoding from the edge the request is made. While no request is pending it equals grp_en_o, and grp_en_o changes only when the two differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_i | input | 1 | One instruction committed this clock |
| cyc_inc_i | input | CINC_W | Core cycles elapsed this clock |
| nrg_inc_i | input | EINC_W | Energy estimate increment this clock |
| drain_ok_i | input | 1 | Groups beyond the requested smaller size are empty |
| hold_epochs_i | input | HOLD_W | Epochs to keep a chosen size before resampling |
| grp_en_o | output | NUM_GROUPS | Bank-group enable mask in force |
| tgt_en_o | output | NUM_GROUPS | Bank-group mask requested |

## Verification
The bench builds the controller with eight groups (levels 0 to 3), an initial level of 1 and an epoch of only four commits. With these values a round finishes in a few dozen cycles, and both range limits can be reached within a few rounds. The bench drives cycle and energy increments from a per-level table, looked up from the mask the design shows. This makes every sample's cost exact, and the full timeline of size requests and size changes can be predicted by arithmetic. Five cost tables and hold counts from 0 to 3 cover these cases: climbing to the top limit, sinking to the bottom limit, ties in both priority orders, and a case where squaring the cycle count changes the winner. A fixed three-cycle drain delay holds back every shrink.

// File: rtl/win_scale_pkg.sv
package win_scale_pkg;

  typedef enum logic [1:0] {
    ST_APPLY = 2'd0,
    ST_MEAS  = 2'd1,
    ST_EVAL  = 2'd2
  } wsc_state_e;

  typedef enum logic [1:0] {
    PH_CUR  = 2'd0,
    PH_HALF = 2'd1,
    PH_DBL  = 2'd2,
    PH_HOLD = 2'd3
  } wsc_phase_e;

endpackage

// File: rtl/wsc_mask_dec.sv
module wsc_mask_dec #(
  parameter int MAX_LVL = 3,
  parameter int LVL_W   = 2,
  localparam int NG     = 1 << MAX_LVL
) (
  input  logic [LVL_W-1:0] lvl_i,
  output logic [NG-1:0]    mask_o
);
  // group g is on when 2^lvl > g, i.e. lvl >= ceil(log2(g+1))
  for (genvar g = 0; g < NG; g++) begin : g_bit
    localparam int NEED = $clog2(g + 1);
    assign mask_o[g] = ({1'b0, lvl_i} >= (LVL_W + 1)'(NEED));
  end
endmodule

// File: rtl/wsc_epoch_ctr.sv
module wsc_epoch_ctr #(
  parameter int EPOCH_INSTR = 1000000,
  localparam int CNT_W      = (EPOCH_INSTR > 1) ? $clog2(EPOCH_INSTR) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  input  logic commit_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EPOCH_INSTR - 1);

  logic [CNT_W-1:0] cnt;

  assign done_o = en_i && commit_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
    end else if (en_i && commit_i) begin
      cnt <= done_o ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wsc_meter.sv
module wsc_meter #(
  parameter int CINC_W  = 4,
  parameter int EINC_W  = 12,
  parameter int CYC_W   = 28,
  parameter int ENA_W   = 36,
  localparam int COST_W = 2 * CYC_W + ENA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [CINC_W-1:0] cyc_inc_i,
  input  logic [EINC_W-1:0] nrg_inc_i,
  output logic [COST_W-1:0] cost_o
);
  logic [CYC_W-1:0] cyc_acc;
  logic [ENA_W-1:0] ena_acc;
  logic [CYC_W:0]   cyc_sum;
  logic [ENA_W:0]   ena_sum;
  logic [COST_W-1:0] cyc_ext, ena_ext;

  // saturating accumulation: a pinned value still ranks as "very costly"
  assign cyc_sum = {1'b0, cyc_acc} + (CYC_W + 1)'(cyc_inc_i);
  assign ena_sum = {1'b0, ena_acc} + (ENA_W + 1)'(nrg_inc_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cyc_acc <= '0;
      ena_acc <= '0;
    end else if (en_i) begin
      cyc_acc <= cyc_sum[CYC_W] ? '1 : cyc_sum[CYC_W-1:0];
      ena_acc <= ena_sum[ENA_W] ? '1 : ena_sum[ENA_W-1:0];
    end
  end

  assign cyc_ext = COST_W'(cyc_acc);
  assign ena_ext = COST_W'(ena_acc);
  assign cost_o  = cyc_ext * cyc_ext * ena_ext;
endmodule

// File: rtl/wsc_size_fsm.sv
module wsc_size_fsm #(
  parameter int MIN_LVL  = 0,
  parameter int MAX_LVL  = 3,
  parameter int INIT_LVL = 1,
  parameter int LVL_W    = 2,
  parameter int COST_W   = 92,
  parameter int HOLD_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drain_ok_i,
  input  logic              epoch_done_i,
  input  logic [HOLD_W-1:0] hold_epochs_i,
  input  logic [COST_W-1:0] cost_i,
  output logic [LVL_W-1:0]  cur_lvl_o,
  output logic [LVL_W-1:0]  tgt_lvl_o,
  output logic              meas_o,
  output logic              apply_o
);
  import win_scale_pkg::*;

  localparam logic [LVL_W-1:0] MIN_L  = LVL_W'(MIN_LVL);
  localparam logic [LVL_W-1:0] MAX_L  = LVL_W'(MAX_LVL);
  localparam logic [LVL_W-1:0] INIT_L = LVL_W'(INIT_LVL);

  wsc_state_e        st;
  wsc_phase_e        ph, nxt_ph;
  logic [LVL_W-1:0]  cur_lvl, tgt_lvl, base_lvl, best_lvl;
  logic [LVL_W-1:0]  sel_lvl, nxt_tgt;
  logic [COST_W-1:0] best_cost, sel_cost;
  logic [HOLD_W-1:0] hold_cnt;
  logic              apply_ok, has_half, has_dbl, win, hold_last;

  always_comb begin
    apply_ok  = (st == ST_APPLY) && ((tgt_lvl >= cur_lvl) || drain_ok_i);
    has_half  = base_lvl > MIN_L;
    has_dbl   = base_lvl < MAX_L;
    // strict compare: earlier candidates keep ties (present, then smaller)
    win       = (ph == PH_CUR) || (cost_i < best_cost);
    sel_lvl   = win ? cur_lvl : best_lvl;
    sel_cost  = win ? cost_i : best_cost;
    hold_last = ({1'b0, hold_cnt} + 1'b1) >= {1'b0, hold_epochs_i};
    nxt_ph    = PH_HOLD;
    nxt_tgt   = sel_lvl;
    case (ph)
      PH_CUR: begin
        if (has_half) begin
          nxt_ph  = PH_HALF;
          nxt_tgt = base_lvl - 1'b1;
        end else if (has_dbl) begin
          nxt_ph  = PH_DBL;
          nxt_tgt = base_lvl + 1'b1;
        end
      end
      PH_HALF: begin
        if (has_dbl) begin
          nxt_ph  = PH_DBL;
          nxt_tgt = base_lvl + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_APPLY;
      ph        <= PH_CUR;
      cur_lvl   <= INIT_L;
      tgt_lvl   <= INIT_L;
      base_lvl  <= INIT_L;
      best_lvl  <= INIT_L;
      best_cost <= '0;
      hold_cnt  <= '0;
    end else begin
      case (st)
        ST_APPLY: begin
          if (apply_ok) begin
            cur_lvl  <= tgt_lvl;
            hold_cnt <= '0;
            if (ph == PH_HOLD && hold_epochs_i == '0) begin
              ph       <= PH_CUR;
              base_lvl <= tgt_lvl;
            end else begin
              st <= ST_MEAS;
            end
          end
        end
        ST_MEAS: begin
          if (epoch_done_i) begin
            if (ph == PH_HOLD) begin
              if (hold_last) begin
                st       <= ST_APPLY;
                ph       <= PH_CUR;
                base_lvl <= cur_lvl;
              end else begin
                hold_cnt <= hold_cnt + 1'b1;
              end
            end else begin
              st <= ST_EVAL;
            end
          end
        end
        default: begin
          best_lvl  <= sel_lvl;
          best_cost <= sel_cost;
          ph        <= nxt_ph;
          tgt_lvl   <= nxt_tgt;
          st        <= ST_APPLY;
        end
      endcase
    end
  end

  assign cur_lvl_o = cur_lvl;
  assign tgt_lvl_o = tgt_lvl;
  assign meas_o    = (st == ST_MEAS);
  assign apply_o   = apply_ok;
endmodule

// File: rtl/win_scale_ctrl.sv
module win_scale_ctrl #(
  parameter int MIN_LVL     = 0,
  parameter int MAX_LVL     = 3,
  parameter int INIT_LVL    = 1,
  parameter int EPOCH_INSTR = 1000000,
  parameter int CINC_W      = 4,
  parameter int EINC_W      = 12,
  parameter int CYC_W       = 28,
  parameter int ENA_W       = 36,
  parameter int HOLD_W      = 8,
  localparam int NUM_GROUPS = 1 << MAX_LVL,
  localparam int LVL_W      = (MAX_LVL > 0) ? $clog2(MAX_LVL + 1) : 1,
  localparam int COST_W     = 2 * CYC_W + ENA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit_i,
  input  logic [CINC_W-1:0]     cyc_inc_i,
  input  logic [EINC_W-1:0]     nrg_inc_i,
  input  logic                  drain_ok_i,
  input  logic [HOLD_W-1:0]     hold_epochs_i,
  output logic [NUM_GROUPS-1:0] grp_en_o,
  output logic [NUM_GROUPS-1:0] tgt_en_o
);
  logic              meas, apply, epoch_done;
  logic [COST_W-1:0] cost;
  logic [LVL_W-1:0]  cur_lvl, tgt_lvl;

  wsc_epoch_ctr #(.EPOCH_INSTR(EPOCH_INSTR)) u_ctr (
    .clk(clk), .rst(rst), .clr_i(apply), .en_i(meas),
    .commit_i(commit_i), .done_o(epoch_done)
  );

  wsc_meter #(
    .CINC_W(CINC_W), .EINC_W(EINC_W), .CYC_W(CYC_W), .ENA_W(ENA_W)
  ) u_meter (
    .clk(clk), .rst(rst), .clr_i(apply), .en_i(meas),
    .cyc_inc_i(cyc_inc_i), .nrg_inc_i(nrg_inc_i), .cost_o(cost)
  );

  wsc_size_fsm #(
    .MIN_LVL(MIN_LVL), .MAX_LVL(MAX_LVL), .INIT_LVL(INIT_LVL),
    .LVL_W(LVL_W), .COST_W(COST_W), .HOLD_W(HOLD_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .drain_ok_i(drain_ok_i),
    .epoch_done_i(epoch_done), .hold_epochs_i(hold_epochs_i),
    .cost_i(cost), .cur_lvl_o(cur_lvl), .tgt_lvl_o(tgt_lvl),
    .meas_o(meas), .apply_o(apply)
  );

  wsc_mask_dec #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_dec_cur (
    .lvl_i(cur_lvl), .mask_o(grp_en_o)
  );

  wsc_mask_dec #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_dec_tgt (
    .lvl_i(tgt_lvl), .mask_o(tgt_en_o)
  );
endmodule

// File: rtl/win_scale_ctrl_chk.sv
module win_scale_ctrl_chk #(
  parameter int NG      = 8,
  parameter int MIN_LVL = 0,
  parameter int MAX_LVL = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          drain_ok_i,
  input logic [NG-1:0] grp_en_o,
  input logic [NG-1:0] tgt_en_o
);
  function automatic logic legal(input logic [NG-1:0] m);
    int n;
    n = $countones(m);
    return (m != '0) && ((m & (m + 1'b1)) == '0) && ((n & (n - 1)) == 0) &&
           (n >= (1 << MIN_LVL)) && (n <= (1 << MAX_LVL));
  endfunction

  AST_EN_SHAPE: assert property (@(posedge clk) disable iff (rst)
    legal(grp_en_o)); // R2

  AST_TGT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    legal(tgt_en_o)); // R8

  AST_SHRINK_DRAINED: assert property (@(posedge clk) disable iff (rst)
    !drain_ok_i |=> ((grp_en_o & $past(grp_en_o)) == $past(grp_en_o))); // R7

  AST_GROW_NEXT: assert property (@(posedge clk) disable iff (rst)
    (tgt_en_o != grp_en_o && (tgt_en_o & grp_en_o) == grp_en_o)
    |=> grp_en_o == $past(tgt_en_o)); // R7

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
    (tgt_en_o == grp_en_o) |=> $stable(grp_en_o)); // R8
endmodule

bind win_scale_ctrl win_scale_ctrl_chk #(
  .NG(NUM_GROUPS), .MIN_LVL(MIN_LVL), .MAX_LVL(MAX_LVL)
) u_chk (
  .clk(clk), .rst(rst), .drain_ok_i(drain_ok_i),
  .grp_en_o(grp_en_o), .tgt_en_o(tgt_en_o)
);

// File: tb/tb_win_scale_ctrl.sv
module tb_win_scale_ctrl;
  localparam int EPOCH   = 4;
  localparam int HORIZON = 120;
  localparam int DRAIN_D = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       commit_i = 1'b0;
  logic [3:0] cyc_inc_i = '0;
  logic [3:0] nrg_inc_i = '0;
  logic       drain_ok_i = 1'b0;
  logic [3:0] hold_epochs_i = '0;
  logic [7:0] grp_en_o, tgt_en_o;

  win_scale_ctrl #(
    .MIN_LVL(0), .MAX_LVL(3), .INIT_LVL(1), .EPOCH_INSTR(EPOCH),
    .CINC_W(4), .EINC_W(4), .CYC_W(8), .ENA_W(8), .HOLD_W(4)
  ) dut (
    .clk(clk), .rst(rst), .commit_i(commit_i), .cyc_inc_i(cyc_inc_i),
    .nrg_inc_i(nrg_inc_i), .drain_ok_i(drain_ok_i),
    .hold_epochs_i(hold_epochs_i), .grp_en_o(grp_en_o), .tgt_en_o(tgt_en_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int ecnt = 0, wcnt = 0;
  int ct[4], et[4];
  logic rec_on = 1'b0;
  logic [7:0] prev_g, prev_t;
  int og_t[64], ot_t[64], xg_t[64], xt_t[64];
  logic [7:0] og_m[64], ot_m[64], xg_m[64], xt_m[64];
  int nog = 0, not_ = 0, nxg = 0, nxt = 0;

  function automatic logic [7:0] mask_of(input int l);
    return 8'((1 << (1 << l)) - 1);
  endfunction

  function automatic int lvl_of(input logic [7:0] m);
    case ($countones(m))
      1: return 0;
      2: return 1;
      4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int cost(input int l);
    return ct[l] * ct[l] * et[l];
  endfunction

  task automatic check(input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else ecnt <= ecnt + 1;
  end

  // input driving, drain emulation and change monitor, all away from posedge
  always @(negedge clk) begin
    if (rst) begin
      commit_i   = 1'b0;
      cyc_inc_i  = '0;
      nrg_inc_i  = '0;
      drain_ok_i = 1'b0;
      wcnt       = 0;
      prev_g     = grp_en_o;
      prev_t     = tgt_en_o;
    end else begin
      commit_i  = 1'b1;
      cyc_inc_i = 4'(ct[lvl_of(grp_en_o)]);
      nrg_inc_i = 4'(et[lvl_of(grp_en_o)]);
      if (tgt_en_o != grp_en_o && (tgt_en_o & grp_en_o) == tgt_en_o) begin
        wcnt++;
        if (wcnt >= DRAIN_D) drain_ok_i = 1'b1;
      end else begin
        wcnt = 0;
        drain_ok_i = 1'b0;
      end
      if (rec_on && ecnt <= HORIZON) begin
        if (grp_en_o != prev_g && nog < 64) begin
          og_t[nog] = ecnt; og_m[nog] = grp_en_o; nog++;
        end
        if (tgt_en_o != prev_t && not_ < 64) begin
          ot_t[not_] = ecnt; ot_m[not_] = tgt_en_o; not_++;
        end
      end
      prev_g = grp_en_o;
      prev_t = tgt_en_o;
    end
  end

  task automatic add_ev(input int t, input int l, input logic is_tgt);
    if (t > HORIZON) return;
    if (is_tgt) begin
      if (nxt < 64) begin xt_t[nxt] = t; xt_m[nxt] = mask_of(l); nxt++; end
    end else begin
      if (nxg < 64) begin xg_t[nxg] = t; xg_m[nxg] = mask_of(l); nxg++; end
    end
  endtask

  // R3 R4 R5 R6 R7: arithmetic timeline of requests and applied sizes
  task automatic build_expected(input int h);
    int cur, t, base, best, bc, a, te, cand;
    nxg = 0; nxt = 0;
    cur = 1; t = 1;
    while (t <= HORIZON) begin
      base = cur; best = base; bc = cost(base); a = t;
      for (int k = 0; k < 2; k++) begin
        cand = (k == 0) ? base - 1 : base + 1;
        if (cand < 0 || cand > 3) continue;
        te = a + EPOCH + 1;
        add_ev(te, cand, 1'b1);
        a = te + ((cand < cur) ? DRAIN_D : 1);
        add_ev(a, cand, 1'b0);
        cur = cand;
        if (cost(cand) < bc) begin bc = cost(cand); best = cand; end
      end
      te = a + EPOCH + 1;
      if (best != cur) begin
        add_ev(te, best, 1'b1);
        a = te + ((best < cur) ? DRAIN_D : 1);
        add_ev(a, best, 1'b0);
        cur = best;
      end else begin
        a = te + 1;
      end
      t = (h == 0) ? a + 1 : a + EPOCH * h + 1;
    end
  endtask

  task automatic set_scen(input int s, output int h, output string tag);
    case (s)
      0: begin ct = '{8, 4, 2, 1}; et = '{1, 1, 1, 1}; h = 0; tag = "R4 upper clamp"; end
      1: begin ct = '{1, 1, 1, 1}; et = '{1, 1, 3, 4}; h = 2; tag = "R5 tie present-vs-smaller"; end
      2: begin ct = '{1, 1, 1, 1}; et = '{1, 2, 3, 4}; h = 1; tag = "R4 lower clamp"; end
      3: begin ct = '{1, 1, 1, 1}; et = '{2, 5, 2, 9}; h = 3; tag = "R5 tie smaller-vs-larger"; end
      default: begin ct = '{4, 2, 3, 4}; et = '{4, 4, 2, 2}; h = 0; tag = "R5 squared cycles"; end
    endcase
  endtask

  initial begin
    int h;
    string tag;
    ct = '{1, 1, 1, 1};
    et = '{1, 1, 1, 1};
    for (int s = 0; s < 5; s++) begin
      set_scen(s, h, tag);
      hold_epochs_i = 4'(h);
      @(negedge clk);
      rst = 1'b1;
      rec_on = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "reset enable mask", int'(grp_en_o), 8'h03);
      check("R1", "reset target mask", int'(tgt_en_o), 8'h03);
      nog = 0; not_ = 0;
      rst = 1'b0;
      rec_on = 1'b1;
      @(negedge clk);
      check("R1", "enable mask after reset", int'(grp_en_o), 8'h03);
      while (ecnt <= HORIZON) @(negedge clk);
      rec_on = 1'b0;
      build_expected(h);
      check(tag, "R3/R6 applied-size change count", nog, nxg);
      check(tag, "R8 request change count", not_, nxt);
      for (int i = 0; i < nxg && i < nog; i++) begin
        check(tag, $sformatf("R3/R6/R7 apply edge #%0d", i), og_t[i], xg_t[i]);
        check(tag, $sformatf("R2/R5 applied mask #%0d", i), int'(og_m[i]), int'(xg_m[i]));
      end
      for (int i = 0; i < nxt && i < not_; i++) begin
        check(tag, $sformatf("R8 request edge #%0d", i), ot_t[i], xt_t[i]);
        check(tag, $sformatf("R8 request mask #%0d", i), int'(ot_m[i]), int'(xt_m[i]));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule